// File: doc/BRIEF.md
# Reshapable Dual-Clock Block Memory

This block is a 4096-bit simple dual-port memory. One port only writes and the other only reads. Each port has its own clock, its own clock enable and its own access enable. The storage is always 256 physical words of 16 bits. A parameter reshapes that array into one of four logical shapes: 2048 x 2, 1024 x 4, 512 x 8 or 256 x 16. The block maps each logical address onto a physical word and a slice within it.

Logical data always sits in the low bits of the 16-bit data buses. In the full-width shape the write port also honours a per-bit protection mask. Initial contents come from a packed parameter. A second parameter turns the block into a ROM: the write port is then inert and the contents stay as loaded.

Top module: `shaped_bram`

## Requirements
- R1: `MODE` selects the shape, with logical width W = 2 << `MODE`: 0 gives 2048x2, 1 gives 1024x4, 2 gives 512x8 and 3 gives 256x16. Write data is taken from `wr_data[W-1:0]`. Read data appears in `rd_data[W-1:0]`, and the bits of `rd_data` above W read as 0.
- R2: Let S = 3 - `MODE`. The physical word index is bits [7:0] of (address >> S), and the slice is the low S address bits. Slice s occupies physical bits [s*W +: W]. In the 16-bit shape, address bits [10:8] are ignored.
- R3: Reads are synchronous. When `rd_clk_en` and `rd_en` are both 1 at a rising edge of `rd_clk`, `rd_data` shows, after that edge, the data at the `rd_addr` sampled on that edge.
- R4: `rd_data` is 0 from power-up until the first enabled read. It keeps its value across any `rd_clk` edge where `rd_clk_en` or `rd_en` is 0.
- R5: A write takes effect at a rising edge of `wr_clk` only when `wr_clk_en` and `wr_en` are both 1.
- R6: In the 16-bit shape, a `wr_mask` bit of 1 keeps that stored bit and a 0 lets it be written. In the narrow shapes `wr_mask` has no effect.
- R7: When one clock drives both ports and the same address is read and written on the same edge, the read returns the data held before the write.
- R8: At power-up, physical word i holds `INIT[16*i +: 16]`.
- R9: With `ROM_ONLY` = 1, no write changes the contents.
- R10: With unrelated read and write clocks, data written on `wr_clk` is returned by a later enabled read on `rd_clk`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write-port clock |
| wr_clk_en | input | 1 | Write-port clock enable |
| wr_en | input | 1 | Write enable |
| wr_addr | input | 11 | Logical write address |
| wr_data | input | 16 | Write data, low W bits used |
| wr_mask | input | 16 | Per-bit protect mask, 16-bit shape only |
| rd_clk | input | 1 | Read-port clock |
| rd_clk_en | input | 1 | Read-port clock enable |
| rd_en | input | 1 | Read enable |
| rd_addr | input | 11 | Logical read address |
| rd_data | output | 16 | Registered read data, low W bits valid |

## Verification
The assertions assume that the read and write clocks are free-running and that every control and address input is settled at each rising edge of the clock it belongs to. The collision property also assumes that any read and write of the same word on unrelated clocks never fall on the same instant. The bench drives all inputs on falling edges. Only the instance that shares one clock between its ports performs a same-address read and write, so the only collision the bench creates is the defined same-clock case.

// File: rtl/shaped_bram.sv
module shaped_bram #(
  parameter logic [1:0]    MODE     = 2'd3,
  parameter bit            ROM_ONLY = 1'b0,
  parameter logic [4095:0] INIT     = '0
) (
  input  logic        wr_clk,
  input  logic        wr_clk_en,
  input  logic        wr_en,
  input  logic [10:0] wr_addr,
  input  logic [15:0] wr_data,
  input  logic [15:0] wr_mask,
  input  logic        rd_clk,
  input  logic        rd_clk_en,
  input  logic        rd_en,
  input  logic [10:0] rd_addr,
  output logic [15:0] rd_data
);
  localparam int         W    = 2 << MODE;
  localparam int         SB   = 3 - int'(MODE);
  localparam logic [15:0] LOW = 16'((17'h1 << W) - 17'h1);
  localparam logic [2:0] SLM  = 3'((4'h1 << SB) - 4'h1);

  logic [15:0] mem [256];
  initial for (int i = 0; i < 256; i++) mem[i] = INIT[i*16 +: 16];

  logic [7:0]  wr_word, rd_word;
  logic [2:0]  wr_sl, rd_sl;
  logic [15:0] wr_din, bit_en;
  logic        wr_go, rd_go;

  assign wr_word = 8'(wr_addr >> SB);
  assign wr_sl   = wr_addr[2:0] & SLM;
  assign wr_din  = (wr_data & LOW) << (wr_sl * W);
  assign bit_en  = (MODE == 2'd3) ? ~wr_mask : (LOW << (wr_sl * W));
  assign wr_go   = !ROM_ONLY && wr_clk_en && wr_en;

  always_ff @(posedge wr_clk)
    if (wr_go)
      for (int b = 0; b < 16; b++)
        if (bit_en[b]) mem[wr_word][b] <= wr_din[b];

  logic [15:0] rd_q = '0;
  logic [2:0]  rd_sl_q = '0;

  assign rd_word = 8'(rd_addr >> SB);
  assign rd_sl   = rd_addr[2:0] & SLM;
  assign rd_go   = rd_clk_en && rd_en;

  always_ff @(posedge rd_clk)
    if (rd_go) begin
      rd_q    <= mem[rd_word];
      rd_sl_q <= rd_sl;
    end

  assign rd_data = (rd_q >> (rd_sl_q * W)) & LOW;

  logic wr_primed = 1'b0;
  logic rd_primed = 1'b0;
  always_ff @(posedge wr_clk) wr_primed <= 1'b1;
  always_ff @(posedge rd_clk) rd_primed <= 1'b1;

  p_write_lands_r5: assert property (@(posedge wr_clk) disable iff (!wr_primed)
    wr_go |=> ((mem[$past(wr_word)] ^ $past(wr_din)) & $past(bit_en)) == 16'h0);

  p_mask_keep_r6: assert property (@(posedge wr_clk) disable iff (!wr_primed)
    (MODE == 2'd3) && wr_go && (wr_mask == 16'hFFFF) |=> mem[$past(wr_word)] == $past(mem[wr_word]));

  if (ROM_ONLY) begin : g_rom_chk
    p_rom_frozen_r9: assert property (@(posedge wr_clk) disable iff (!wr_primed)
      wr_clk_en && wr_en |=> mem[$past(wr_word)] == $past(mem[wr_word]));
  end

  p_read_fetch_r3: assert property (@(posedge rd_clk) disable iff (!rd_primed)
    rd_go |=> rd_q == $past(mem[rd_word]));

  p_hold_r4: assert property (@(posedge rd_clk) disable iff (!rd_primed)
    !rd_go |=> $stable(rd_data));
endmodule

// File: tb/shaped_bram_bench.sv
module shaped_bram_bench;
  localparam int CLK_NS  = 10;
  localparam int RCLK_NS = 14;

  function automatic logic [4095:0] mk_init(input logic [15:0] seed);
    logic [4095:0] r;
    for (int i = 0; i < 256; i++) r[i*16 +: 16] = 16'(i * 16'h0A3B) ^ seed;
    return r;
  endfunction
  localparam logic [4095:0] INIT_A = mk_init(16'h5A00);
  localparam logic [4095:0] INIT_N = mk_init(16'h3C77);
  localparam logic [4095:0] INIT_R = mk_init(16'hC381);

  logic clk = 0, rclk = 0;
  always #(CLK_NS/2) clk = ~clk;
  always #(RCLK_NS/2) rclk = ~rclk;

  int n_chk = 0, n_bad = 0;
  task automatic chk(input string tag, input logic [15:0] got, input logic [15:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  // main instance: 256x16, one clock for both ports
  logic a_wce = 0, a_we = 0, a_rce = 0, a_re = 0;
  logic [10:0] a_wa = 0, a_ra = 0;
  logic [15:0] a_wd = 0, a_wm = 0, a_rd;
  shaped_bram #(.MODE(2'd3), .ROM_ONLY(1'b0), .INIT(INIT_A)) u_shaped_bram (
    .wr_clk(clk), .wr_clk_en(a_wce), .wr_en(a_we), .wr_addr(a_wa), .wr_data(a_wd), .wr_mask(a_wm),
    .rd_clk(clk), .rd_clk_en(a_rce), .rd_en(a_re), .rd_addr(a_ra), .rd_data(a_rd));

  // narrow instance: 2048x2, separate read clock
  logic n_wce = 0, n_we = 0, n_rce = 0, n_re = 0;
  logic [10:0] n_wa = 0, n_ra = 0;
  logic [15:0] n_wd = 0, n_wm = 0, n_rd;
  shaped_bram #(.MODE(2'd0), .ROM_ONLY(1'b0), .INIT(INIT_N)) u_shaped_bram_nar (
    .wr_clk(clk), .wr_clk_en(n_wce), .wr_en(n_we), .wr_addr(n_wa), .wr_data(n_wd), .wr_mask(n_wm),
    .rd_clk(rclk), .rd_clk_en(n_rce), .rd_en(n_re), .rd_addr(n_ra), .rd_data(n_rd));

  // ROM instance: 512x8
  logic r_wce = 0, r_we = 0, r_rce = 0, r_re = 0;
  logic [10:0] r_wa = 0, r_ra = 0;
  logic [15:0] r_wd = 0, r_rd;
  shaped_bram #(.MODE(2'd2), .ROM_ONLY(1'b1), .INIT(INIT_R)) u_shaped_bram_rom (
    .wr_clk(clk), .wr_clk_en(r_wce), .wr_en(r_we), .wr_addr(r_wa), .wr_data(r_wd), .wr_mask(16'h0),
    .rd_clk(clk), .rd_clk_en(r_rce), .rd_en(r_re), .rd_addr(r_ra), .rd_data(r_rd));

  logic [15:0] ma [256];
  logic [1:0]  nm [2048];
  logic [15:0] qa[$], qn[$], qr[$];
  string       ta[$], tn[$], tr[$];

  // monitors
  logic a_fire = 0, n_fire = 0, r_fire = 0;
  always @(posedge clk)  a_fire <= a_rce && a_re;
  always @(posedge rclk) n_fire <= n_rce && n_re;
  always @(posedge clk)  r_fire <= r_rce && r_re;

  always @(negedge clk) if (a_fire) begin
    if (qa.size() == 0) chk("R3 unexpected read main", a_rd, 16'hxxxx);
    else chk(ta.pop_front(), a_rd, qa.pop_front());
  end
  always @(negedge rclk) if (n_fire) begin
    if (qn.size() == 0) chk("R3 unexpected read narrow", n_rd, 16'hxxxx);
    else chk(tn.pop_front(), n_rd, qn.pop_front());
  end
  always @(negedge clk) if (r_fire) begin
    if (qr.size() == 0) chk("R3 unexpected read rom", r_rd, 16'hxxxx);
    else chk(tr.pop_front(), r_rd, qr.pop_front());
  end

  // drivers
  task automatic a_wr_raw(input logic ce, input logic we, input logic [10:0] ad,
                          input logic [15:0] d, input logic [15:0] m);
    @(negedge clk);
    a_wce = ce; a_we = we; a_wa = ad; a_wd = d; a_wm = m;
    if (ce && we) ma[ad[7:0]] = (ma[ad[7:0]] & m) | (d & ~m);
    @(negedge clk);
    a_wce = 0; a_we = 0;
  endtask

  task automatic a_read(input logic [10:0] ad, input string tag);
    @(negedge clk);
    a_rce = 1; a_re = 1; a_ra = ad;
    qa.push_back(ma[ad[7:0]]); ta.push_back(tag);
    @(negedge clk);
    a_rce = 0; a_re = 0;
  endtask

  task automatic a_collide(input logic [10:0] ad, input logic [15:0] d);
    @(negedge clk);
    a_wce = 1; a_we = 1; a_wa = ad; a_wd = d; a_wm = 16'h0;
    a_rce = 1; a_re = 1; a_ra = ad;
    qa.push_back(ma[ad[7:0]]); ta.push_back("R7 read-during-write returns old data");
    ma[ad[7:0]] = d;
    @(negedge clk);
    a_wce = 0; a_we = 0; a_rce = 0; a_re = 0;
  endtask

  task automatic n_write(input logic [10:0] ad, input logic [15:0] d, input logic [15:0] m);
    @(negedge clk);
    n_wce = 1; n_we = 1; n_wa = ad; n_wd = d; n_wm = m;
    nm[ad] = d[1:0];
    @(negedge clk);
    n_wce = 0; n_we = 0;
  endtask

  task automatic n_read(input logic [10:0] ad, input string tag);
    @(negedge rclk);
    n_rce = 1; n_re = 1; n_ra = ad;
    qn.push_back({14'h0, nm[ad]}); tn.push_back(tag);
    @(negedge rclk);
    n_rce = 0; n_re = 0;
  endtask

  function automatic logic [15:0] rom_exp(input int ad);
    return {8'h0, INIT_R[(ad >> 1)*16 + (ad % 2)*8 +: 8]};
  endfunction

  task automatic r_read(input logic [10:0] ad, input string tag);
    @(negedge clk);
    r_rce = 1; r_re = 1; r_ra = ad;
    qr.push_back(rom_exp(int'(ad))); tr.push_back(tag);
    @(negedge clk);
    r_rce = 0; r_re = 0;
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    #(CLK_NS * 100000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    logic [15:0] v;
    for (int i = 0; i < 256; i++) ma[i] = INIT_A[i*16 +: 16];
    for (int a = 0; a < 2048; a++) nm[a] = INIT_N[(a >> 3)*16 + (a % 8)*2 +: 2];

    @(negedge clk);
    chk("R4 power-up read data main", a_rd, 16'h0);
    chk("R4 power-up read data narrow", n_rd, 16'h0);

    // R8 initial contents
    a_read(11'd3, "R8 init word 3");
    a_read(11'd255, "R8 init last word");
    v = ma[255];

    // R4 hold with one enable low
    @(negedge clk); a_rce = 1; a_re = 0; a_ra = 11'd3;
    @(negedge clk); a_rce = 0;
    chk("R4 hold with rd_en low", a_rd, v);
    @(negedge clk); a_rce = 0; a_re = 1; a_ra = 11'd3;
    @(negedge clk); a_re = 0;
    chk("R4 hold with rd_clk_en low", a_rd, v);

    // R3 write then read
    a_wr_raw(1, 1, 11'h010, 16'h1234, 16'h0);
    a_read(11'h010, "R3 read after write");

    // R2 upper address bits ignored in 16-bit shape
    a_wr_raw(1, 1, 11'h705, 16'hBEEF, 16'h0);
    a_read(11'h005, "R2 write via aliased address");
    a_read(11'h305, "R2 read via aliased address");

    // R5 write gating
    a_wr_raw(0, 1, 11'h010, 16'hFFFF, 16'h0);
    a_wr_raw(1, 0, 11'h010, 16'hFFFF, 16'h0);
    a_read(11'h010, "R5 gated writes leave word intact");

    // R6 mask in 16-bit shape
    a_wr_raw(1, 1, 11'h010, 16'hABCD, 16'h00FF);
    a_read(11'h010, "R6 masked write keeps low byte");
    a_wr_raw(1, 1, 11'h010, 16'h0000, 16'hFFFF);
    a_read(11'h010, "R6 full mask blocks write");

    // R7 same-clock collision
    a_collide(11'h020, 16'h7E57);
    a_read(11'h020, "R7 new data after collision");

    // narrow 2048x2: mapping, width, mask ignored, separate clocks
    n_read(11'd0, "R2 narrow init slice 0");
    n_read(11'd13, "R2 narrow init slice 5 of word 1");
    n_read(11'd2047, "R2 narrow init last slice");
    n_write(11'd13, 16'hFFF2, 16'hFFFF);
    n_read(11'd13, "R6 narrow write ignores mask R10 cross-clock");
    n_read(11'd12, "R2 narrow neighbour slice unchanged");
    n_read(11'd14, "R2 narrow neighbour slice unchanged above");
    n_write(11'd1000, 16'h0001, 16'h0);
    n_read(11'd1000, "R1 narrow upper bits read zero R10");

    // ROM 512x8
    r_read(11'd7, "R8 rom init slice");
    @(negedge clk); r_wce = 1; r_we = 1; r_wa = 11'd7; r_wd = 16'h00FF ^ rom_exp(7);
    @(negedge clk); r_wce = 0; r_we = 0;
    r_read(11'd7, "R9 rom ignores write");
    r_read(11'd510, "R1 rom 8-bit width");

    repeat (4) @(negedge rclk);
    chk("R3 all main reads returned", 16'(qa.size()), 16'h0);
    chk("R3 all narrow reads returned", 16'(qn.size()), 16'h0);
    finish_run();
  end
endmodule